// File: doc/BRIEF.md
# Banked Bit-Addressable Scratch Memory

This unit is the on-chip data store of a small 8-bit controller core. It holds 128 bytes of RAM and turns three kinds of operand reference into RAM locations. A 3-bit register number is resolved inside one of four register banks. A byte address is either given directly or read from pointer register 0 or 1 of the active bank. A single-bit address names one bit in a 16-byte window of RAM or one bit of a special-function register.

Byte addresses from 80h upward do not touch RAM. They are handed to a pass-through port that leads to the special-function registers outside this unit. A bit set or clear is a read-modify-write of the byte that holds the bit and finishes in one clock. When the bit lives in a special-function register, the unit reads that register, patches the bit and presents the whole byte for writing.

Reads are combinational and writes land on the rising clock edge. The core's instruction logic drives all ports directly. The two bank-select bits come from the core's status word.

Top module: `idm_core`

## Requirements
- R1: A register operand with number r (0 to 7) and active bank b (0 to 3) reads and writes RAM byte b*8 + r. reg_rdata shows that byte's current value combinationally.
- R2: A change of bank_sel takes effect in the same cycle. While rst_n is low, the unit uses bank 0 whatever bank_sel holds, and it ignores every write request on every port (RAM unchanged, sfr_we and sfr_bit_we low).
- R3: A direct byte address below 80h reads RAM combinationally, and a byte write lands at the next rising edge. A read of the byte being written in the same cycle returns the old value.
- R4: A byte address of 80h or above leaves RAM untouched. sfr_addr carries the address, byte_rdata returns sfr_rdata, and a write appears as sfr_we with sfr_wdata.
- R5: With byte_ind high, the effective byte address is the content of R0 (byte_ptr=0) or R1 (byte_ptr=1) of the active bank. That address is then decoded as in R3 and R4.
- R6: A bit address n below 80h names bit n mod 8 of RAM byte 20h + n/8, so bytes 20h to 2Fh hold bits 00h to 7Fh. bit_rdata shows that bit combinationally.
- R7: A bit set or clear on the RAM window changes only the addressed bit at the next edge. The other seven bits of the byte stay as they were, and the byte stays readable and writable as a whole byte.
- R8: A bit address n of 80h or above maps to special-function byte n with its low three bits cleared, bit n mod 8 (so AFh is bit 7 of A8h). sfr_bit_addr carries that byte, and bit_rdata returns the bit from sfr_bit_rdata. A set or clear raises sfr_bit_we with sfr_bit_wdata equal to sfr_bit_rdata with only that bit changed.
- R9: If bit_set and bit_clr are both high, the bit is cleared.
- R10: When several ports write the same RAM byte in one cycle, the byte port overrides the register port. A bit write is then applied to the result, changing only its own bit.
- R11: sfr_we is high only for a byte write whose effective address is 80h or above. sfr_bit_we is high only for a bit set or clear whose address is 80h or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset: forces bank 0 and blocks writes |
| bank_sel | input | 2 | Active register bank, bit 1 most significant |
| reg_num | input | 3 | Register number within the bank |
| reg_we | input | 1 | Register write request |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| byte_addr | input | 8 | Direct byte address |
| byte_ind | input | 1 | Use pointer register instead of byte_addr |
| byte_ptr | input | 1 | Pointer register choice: 0 is R0, 1 is R1 |
| byte_we | input | 1 | Byte write request |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data |
| bit_addr | input | 8 | Bit address |
| bit_set | input | 1 | Set the addressed bit |
| bit_clr | input | 1 | Clear the addressed bit |
| bit_rdata | output | 1 | Value of the addressed bit |
| sfr_addr | output | 8 | Effective byte address forwarded to the special-function registers |
| sfr_we | output | 1 | Special-function byte write strobe |
| sfr_wdata | output | 8 | Special-function byte write data |
| sfr_rdata | input | 8 | Special-function byte read data |
| sfr_bit_addr | output | 8 | Special-function byte that holds the addressed bit |
| sfr_bit_we | output | 1 | Special-function write strobe for a bit update |
| sfr_bit_wdata | output | 8 | Patched special-function byte for a bit update |
| sfr_bit_rdata | input | 8 | Special-function byte read for a bit access |

## Verification
Every read result appears in the cycle its inputs are applied, with no register on the way. Every RAM write becomes visible in the cycle after the rising edge that takes it. The bench drives inputs 1 ns after a rising edge and compares the combinational outputs against its model 1 ns later, mid-cycle. It commits the model's writes only at the following edge, so a same-cycle read is always compared with the old value. Directed corner checks read a written byte back in the next cycle, after exactly one edge.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned POS_W     = $clog2(BYTE_W);
  localparam int unsigned REG_W     = 3;
  localparam int unsigned BANK_W    = 2;
  localparam int unsigned RAM_BYTES = 128;
  localparam int unsigned RAM_AW    = $clog2(RAM_BYTES);
  localparam logic [BYTE_W-1:0] BIT_WIN_BASE = 8'h20;

  typedef logic [BYTE_W-1:0] byte_t;

  // Register operand inside the selected bank.
  function automatic logic [RAM_AW-1:0] reg_to_ram(logic [BANK_W-1:0] bank,
                                                   logic [REG_W-1:0] rnum);
    return {bank, rnum};
  endfunction

  // Byte that carries a given bit address (RAM window or SFR space).
  function automatic byte_t bit_home(byte_t baddr);
    if (baddr[BYTE_W-1])
      return {baddr[BYTE_W-1:POS_W], {POS_W{1'b0}}};
    return BIT_WIN_BASE + {{(BYTE_W-4){1'b0}}, baddr[POS_W+3:POS_W]};
  endfunction

  // Read-modify-write of one bit; clear wins over set.
  function automatic byte_t bit_apply(byte_t old, logic [POS_W-1:0] pos,
                                      logic set_b, logic clr_b);
    byte_t r;
    r = old;
    if (clr_b)      r[pos] = 1'b0;
    else if (set_b) r[pos] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/idm_resolve.sv
module idm_resolve
  import idm_pkg::*;
(
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [REG_W-1:0]  reg_num,
  input  byte_t             byte_addr,
  input  logic              byte_ind,
  input  logic              byte_ptr,
  input  byte_t             ptr_val,
  input  byte_t             bit_addr,
  output logic [RAM_AW-1:0] reg_idx,
  output logic [RAM_AW-1:0] ptr_idx,
  output byte_t             eff_addr,
  output logic              byte_in_ram,
  output byte_t             bit_home_addr,
  output logic              bit_in_ram,
  output logic [POS_W-1:0]  bit_pos
);
  logic [BANK_W-1:0] act_bank;

  // Bank 0 is forced while reset is held.
  assign act_bank      = rst_n ? bank_sel : '0;
  assign reg_idx       = reg_to_ram(act_bank, reg_num);
  assign ptr_idx       = reg_to_ram(act_bank, {{(REG_W-1){1'b0}}, byte_ptr});
  assign eff_addr      = byte_ind ? ptr_val : byte_addr;
  assign byte_in_ram   = ~eff_addr[BYTE_W-1];
  assign bit_home_addr = bit_home(bit_addr);
  assign bit_in_ram    = ~bit_addr[BYTE_W-1];
  assign bit_pos       = bit_addr[POS_W-1:0];

  // R6: RAM bit addresses never leave the 16-byte window.
  always_comb begin
    if (rst_n && bit_in_ram)
      a_r6_window: assert (bit_home_addr >= BIT_WIN_BASE &&
                           bit_home_addr <  BIT_WIN_BASE + 8'd16);
  end
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_idx,
  input  logic [W-1:0]  reg_wdata,
  input  logic          byt_we,
  input  logic [AW-1:0] byt_idx,
  input  logic [W-1:0]  byt_wdata,
  input  logic          bit_we,
  input  logic [AW-1:0] bit_idx,
  input  logic [PW-1:0] bit_pos,
  input  logic          bit_clr,
  input  logic [AW-1:0] ptr_idx,
  output logic [W-1:0]  ptr_rd,
  output logic [W-1:0]  reg_rd,
  output logic [W-1:0]  byt_rd,
  output logic [W-1:0]  bit_rd
);
  logic [W-1:0] mem [DEPTH];

  assign ptr_rd = mem[ptr_idx];
  assign reg_rd = mem[reg_idx];
  assign byt_rd = mem[byt_idx];
  assign bit_rd = mem[bit_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [W-1:0] nxt;
    always_comb begin
      nxt = mem[i];
      if (reg_we && reg_idx == AW'(i)) nxt = reg_wdata;
      if (byt_we && byt_idx == AW'(i)) nxt = byt_wdata;
      if (bit_we && bit_idx == AW'(i)) nxt[bit_pos] = ~bit_clr;
    end
    always_ff @(posedge clk) mem[i] <= nxt;
  end

  // R3: an uncontested byte write lands at the next edge.
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (byt_we && !(bit_we && bit_idx == byt_idx))
    |=> mem[$past(byt_idx)] == $past(byt_wdata));

  // R7: a bit write that no byte or register write contests alters one bit only.
  a_r7_bit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !(byt_we && byt_idx == bit_idx) && !(reg_we && reg_idx == bit_idx))
    |=> ((mem[$past(bit_idx)] ^ $past(bit_rd)) & ~(W'(1) << $past(bit_pos))) == '0);

  // R9 / R10: a clear (alone or with set) always leaves the bit at 0.
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && bit_clr) |=> mem[$past(bit_idx)][$past(bit_pos)] == 1'b0);
endmodule

// File: rtl/idm_core.sv
module idm_core
  import idm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bank_sel,
  input  logic [2:0] reg_num,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] byte_addr,
  input  logic       byte_ind,
  input  logic       byte_ptr,
  input  logic       byte_we,
  input  logic [7:0] byte_wdata,
  output logic [7:0] byte_rdata,
  input  logic [7:0] bit_addr,
  input  logic       bit_set,
  input  logic       bit_clr,
  output logic       bit_rdata,
  output logic [7:0] sfr_addr,
  output logic       sfr_we,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata,
  output logic [7:0] sfr_bit_addr,
  output logic       sfr_bit_we,
  output logic [7:0] sfr_bit_wdata,
  input  logic [7:0] sfr_bit_rdata
);
  logic [RAM_AW-1:0] reg_idx, ptr_idx;
  byte_t             eff_addr, bit_home_addr;
  logic              byte_in_ram, bit_in_ram;
  logic [POS_W-1:0]  bit_pos;
  byte_t             ptr_rd, ram_reg_rd, ram_byt_rd, ram_bit_rd;
  logic              bit_req;
  logic              ram_reg_we, ram_byt_we, ram_bit_we;

  idm_resolve u_resolve (
    .rst_n         (rst_n),
    .bank_sel      (bank_sel),
    .reg_num       (reg_num),
    .byte_addr     (byte_addr),
    .byte_ind      (byte_ind),
    .byte_ptr      (byte_ptr),
    .ptr_val       (ptr_rd),
    .bit_addr      (bit_addr),
    .reg_idx       (reg_idx),
    .ptr_idx       (ptr_idx),
    .eff_addr      (eff_addr),
    .byte_in_ram   (byte_in_ram),
    .bit_home_addr (bit_home_addr),
    .bit_in_ram    (bit_in_ram),
    .bit_pos       (bit_pos)
  );

  assign bit_req    = bit_set | bit_clr;
  assign ram_reg_we = rst_n & reg_we;
  assign ram_byt_we = rst_n & byte_we & byte_in_ram;
  assign ram_bit_we = rst_n & bit_req & bit_in_ram;

  idm_ram #(.DEPTH(RAM_BYTES), .W(BYTE_W)) u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (ram_reg_we),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .byt_we    (ram_byt_we),
    .byt_idx   (eff_addr[RAM_AW-1:0]),
    .byt_wdata (byte_wdata),
    .bit_we    (ram_bit_we),
    .bit_idx   (bit_home_addr[RAM_AW-1:0]),
    .bit_pos   (bit_pos),
    .bit_clr   (bit_clr),
    .ptr_idx   (ptr_idx),
    .ptr_rd    (ptr_rd),
    .reg_rd    (ram_reg_rd),
    .byt_rd    (ram_byt_rd),
    .bit_rd    (ram_bit_rd)
  );

  assign reg_rdata     = ram_reg_rd;
  assign byte_rdata    = byte_in_ram ? ram_byt_rd : sfr_rdata;
  assign bit_rdata     = bit_in_ram ? ram_bit_rd[bit_pos] : sfr_bit_rdata[bit_pos];

  assign sfr_addr      = eff_addr;
  assign sfr_we        = rst_n & byte_we & ~byte_in_ram;
  assign sfr_wdata     = byte_wdata;
  assign sfr_bit_addr  = bit_home_addr;
  assign sfr_bit_we    = rst_n & bit_req & ~bit_in_ram;
  assign sfr_bit_wdata = bit_apply(sfr_bit_rdata, bit_pos, bit_set, bit_clr);

  // R2: no write of any kind leaves the unit while reset is held.
  always_comb begin
    if (!rst_n)
      a_r2_reset_quiet: assert (!sfr_we && !sfr_bit_we &&
                                !ram_reg_we && !ram_byt_we && !ram_bit_we);
  end

  // R4 / R11: a forwarded byte write never also writes RAM.
  a_r4_sfr_spares_ram: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_we |-> (byte_we && !ram_byt_we));

  // R8: the patched SFR byte differs from what was read in the addressed bit only.
  a_r8_sfr_rmw: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_bit_we |-> ((sfr_bit_wdata ^ sfr_bit_rdata) & ~(8'h01 << bit_addr[2:0])) == 8'h00);

  // R11: the bit strobe needs a set or clear request.
  a_r11_bit_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_bit_we |-> (bit_set || bit_clr) && !ram_bit_we);
endmodule

// File: tb/idm_core_tb_top.sv
module idm_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bank_sel;
  logic [2:0] reg_num;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] byte_addr;
  logic       byte_ind, byte_ptr, byte_we;
  logic [7:0] byte_wdata, byte_rdata;
  logic [7:0] bit_addr;
  logic       bit_set, bit_clr, bit_rdata;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       sfr_we;
  logic [7:0] sfr_bit_addr, sfr_bit_wdata, sfr_bit_rdata;
  logic       sfr_bit_we;

  int errors = 0;
  int checks = 0;
  bit ready  = 1'b0;
  logic [7:0] mdl [128];

  always #2 clk = ~clk;

  idm_core dut_i (.*);

  function automatic int tb_home(int ba);
    if (ba >= 128) return ba - (ba % 8);
    return 32 + ba / 8;
  endfunction

  function automatic logic [7:0] tb_bitmod(logic [7:0] old, int pos, logic s, logic c);
    if (c) return old & ~(8'd1 << pos);
    if (s) return old | (8'd1 << pos);
    return old;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    reg_we = 0; byte_we = 0; byte_ind = 0; byte_ptr = 0;
    bit_set = 0; bit_clr = 0; bit_addr = 8'h00; byte_addr = 8'h00;
    reg_num = 0; bank_sel = 0;
    reg_wdata = 0; byte_wdata = 0; sfr_rdata = 0; sfr_bit_rdata = 0;
  endtask

  // Inputs are set 1 ns after an edge; outputs checked 1 ns later; model committed at the next edge.
  task automatic step();
    int eb, ri, eff, home, pos;
    logic [7:0] nm [128];
    #1;
    eb  = rst_n ? int'(bank_sel) : 0;
    ri  = eb * 8 + int'(reg_num);
    if (ready) chk(rst_n ? "R1" : "R2", reg_rdata, mdl[ri]);
    eff = (byte_ind && ready) ? int'(mdl[eb * 8 + int'(byte_ptr)]) : int'(byte_addr);
    if (eff >= 128) begin
      chk("R4", byte_rdata, sfr_rdata);
      chk("R4", sfr_addr, 8'(eff));
      if (byte_we && rst_n) chk("R4", sfr_wdata, byte_wdata);
    end else if (ready) chk(byte_ind ? "R5" : "R3", byte_rdata, mdl[eff]);
    chk("R11", {7'd0, sfr_we}, {7'd0, rst_n && byte_we && eff >= 128});
    home = tb_home(int'(bit_addr));
    pos  = int'(bit_addr) % 8;
    if (bit_addr >= 128) begin
      chk("R8", sfr_bit_addr, 8'(home));
      chk("R8", {7'd0, bit_rdata}, {7'd0, sfr_bit_rdata[pos]});
      if (bit_set || bit_clr)
        chk("R8", sfr_bit_wdata, tb_bitmod(sfr_bit_rdata, pos, bit_set, bit_clr));
    end else if (ready) chk("R6", {7'd0, bit_rdata}, {7'd0, mdl[home][pos]});
    chk("R11", {7'd0, sfr_bit_we}, {7'd0, rst_n && (bit_set || bit_clr) && bit_addr >= 128});
    nm = mdl;
    if (rst_n) begin
      if (reg_we) nm[ri] = reg_wdata;
      if (byte_we && eff < 128) nm[eff] = byte_wdata;
      if ((bit_set || bit_clr) && bit_addr < 128)
        nm[home] = tb_bitmod(nm[home], pos, bit_set, bit_clr);
    end
    @(posedge clk);
    mdl = nm;
    #1;
  endtask

  task automatic peek_byte(input string tag, input logic [7:0] addr, input logic [7:0] exp);
    idle(); byte_addr = addr;
    #1; chk(tag, byte_rdata, exp);
    step();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] saved;
    void'($urandom(32'd5171));
    idle();
    rst_n = 0;
    @(posedge clk); #1;
    // Reset state: write requests must not escape (R2, R11).
    byte_we = 1; byte_addr = 8'h95; bit_set = 1; bit_addr = 8'hB3;
    step();
    idle(); rst_n = 1;
    for (int a = 0; a < 128; a++) begin
      idle(); byte_addr = 8'(a); byte_we = 1; byte_wdata = 8'($urandom);
      step();
    end
    ready = 1'b1;

    for (int n = 0; n < 4000; n++) begin
      bank_sel  = 2'($urandom);
      reg_num   = 3'($urandom);
      reg_we    = ($urandom % 4) == 0;
      reg_wdata = 8'($urandom);
      byte_addr = 8'($urandom);
      byte_ind  = ($urandom % 4) == 0;
      byte_ptr  = 1'($urandom);
      byte_we   = ($urandom % 3) == 0;
      byte_wdata = 8'($urandom);
      bit_addr  = (($urandom % 3) == 0) ? 8'($urandom) : 8'($urandom % 128);
      bit_set   = ($urandom % 3) == 0;
      bit_clr   = ($urandom % 4) == 0;
      sfr_rdata = 8'($urandom);
      sfr_bit_rdata = 8'($urandom);
      step();
    end

    // R7: bit updates keep the rest of byte 2Fh.
    idle(); byte_addr = 8'h2F; byte_we = 1; byte_wdata = 8'h5A; step();
    idle(); bit_addr = 8'h7F; bit_set = 1; step();
    idle(); bit_addr = 8'h79; bit_clr = 1; step();
    peek_byte("R7", 8'h2F, 8'hD8);
    // R9: set and clear together on bit 00h clears bit 0 of byte 20h.
    idle(); byte_addr = 8'h20; byte_we = 1; byte_wdata = 8'hFF; step();
    idle(); bit_addr = 8'h00; bit_set = 1; bit_clr = 1; step();
    peek_byte("R9", 8'h20, 8'hFE);
    // R10: byte port beats register port; bit write layers on top.
    idle(); bank_sel = 2'd1; reg_num = 3'd2; reg_we = 1; reg_wdata = 8'h11;
    byte_addr = 8'h0A; byte_we = 1; byte_wdata = 8'h22; step();
    peek_byte("R10", 8'h0A, 8'h22);
    idle(); byte_addr = 8'h25; byte_we = 1; byte_wdata = 8'h00; bit_addr = 8'h2B; bit_set = 1; step();
    peek_byte("R10", 8'h25, 8'h08);
    // R2: bank 2 register 7 is byte 17h.
    idle(); bank_sel = 2'd2; reg_num = 3'd7; reg_we = 1; reg_wdata = 8'h3C; step();
    peek_byte("R2", 8'h17, 8'h3C);
    // R2: during reset bank 0 is used and writes are dropped.
    saved = mdl[8'h30];
    idle(); rst_n = 0; bank_sel = 2'd3; reg_num = 3'd5; byte_addr = 8'h30;
    byte_we = 1; byte_wdata = ~saved; step();
    rst_n = 1;
    peek_byte("R2", 8'h30, saved);
    // R5: pointer R1 in bank 0 holds 90h, forwarding to SFR space.
    idle(); reg_num = 3'd1; reg_we = 1; reg_wdata = 8'h90; step();
    idle(); byte_ind = 1; byte_ptr = 1; sfr_rdata = 8'h6B; byte_we = 1; byte_wdata = 8'h44;
    #1; chk("R5", sfr_addr, 8'h90); chk("R5", byte_rdata, 8'h6B);
    step();
    // R8: bit AFh is bit 7 of A8h.
    idle(); bit_addr = 8'hAF; bit_set = 1; sfr_bit_rdata = 8'h00;
    #1; chk("R8", sfr_bit_addr, 8'hA8); chk("R8", sfr_bit_wdata, 8'h80);
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule